// File: doc/BRIEF.md
# Age-Ordered Clustered Issue Queue

This block holds integer operations that are waiting to issue and sends them to four execution sub-clusters: two upper (U0, U1) and two lower (L0, L1). Each cycle up to four new operations may be written in. Each operation carries an operation class, a routing code and an 8-bit program-order tag (inum). The class and routing code are turned into one fixed target sub-cluster when the operation is written, and that target never changes while the operation waits.

Each waiting entry raises a request only for its own sub-cluster, and only while its per-slot ready input is high. One arbiter serves the upper pair and a second arbiter serves the lower pair. Each arbiter grants the oldest requester of each of its two sub-clusters, so up to four operations leave per cycle. Age comes from an age matrix that is updated on writes, so the slot number has no effect on priority. A granted entry leaves the queue at the next clock edge. A mispredict flush removes, in one cycle, every entry whose inum is younger than the flush tag.

An occupancy state machine has three states: ST_EMPTY (no entries), ST_OPEN (some entries, at least four free) and ST_FULL (fewer than four free). It has four named transitions. *fill* goes from ST_EMPTY to ST_OPEN. *saturate* goes from ST_EMPTY or ST_OPEN to ST_FULL. *drain* goes from ST_FULL to ST_OPEN. *empty-out* goes from ST_OPEN or ST_FULL to ST_EMPTY. The `full` output is high exactly in ST_FULL.

Top module: `iq_cluster_issue`

## Requirements
- R1: After reset the queue holds no entries, `full` is low and all four `gnt_vld` bits are low.
- R2: The target sub-cluster is fixed when an operation is written. Sub-cluster indices are 0=U0, 1=U1, 2=L0, 3=L1. Class 2'd1 (memory) goes to L0 when route bit 0 is 0 and to L1 when it is 1. Class 2'd2 (shift) goes to U0 when route bit 0 is 0 and to U1 when it is 1. Classes 2'd0 and 2'd3 (any-unit) go to the sub-cluster whose index is the 2-bit route code.
- R3: An entry requests only while it is valid and `slot_rdy[slot]` is high. Write lanes with `ins_vld` set take the lowest-numbered free slots, in lane order (lane 0 first).
- R4: Among the requesters of one sub-cluster, the grant goes to the oldest one. An entry written in an earlier cycle is older than a later one. Within one cycle, a lower lane is older than a higher lane. Slot number plays no part.
- R5: Each sub-cluster grants at most one entry per cycle, so at most four grants are made per cycle. Grants are combinational in the request cycle, and a granted entry is gone after the next clock edge.
- R6: A slot freed by a grant can be taken by a write in the next cycle.
- R7: While `flush_vld` is high, every entry whose inum minus `flush_inum` (modulo 256) lies in 1..127 is removed at the clock edge. Entries equal to or older than the flush tag stay. No grants are made and writes are ignored in that cycle.
- R8: `full` is high when fewer than four slots are free. While it is high, all writes are ignored.
- R9: `gnt_inum[u]` carries the inum of the entry granted on sub-cluster u.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_vld | input | 4 | Per-lane write valid |
| ins_cls | input | 8 | Per-lane 2-bit operation class |
| ins_route | input | 8 | Per-lane 2-bit routing code |
| ins_inum | input | 32 | Per-lane 8-bit program-order tag |
| slot_rdy | input | 20 | Per-slot operand-ready (wakeup) |
| flush_vld | input | 1 | Mispredict flush strobe |
| flush_inum | input | 8 | Tag of the mispredicting operation |
| full | output | 1 | Fewer than four free slots; writes stalled |
| gnt_vld | output | 4 | Per-sub-cluster grant (U0, U1, L0, L1) |
| gnt_inum | output | 32 | Per-sub-cluster 8-bit tag of the granted entry |

## Verification
The assertions check several properties on every cycle:
- no sub-cluster has more than one winner;
- every non-empty request set produces a winner, which shows that the age matrix is a total order;
- granted entries are gone one edge later;
- no entry appears while the queue is full or being flushed;
- `full` agrees with the live entry count;
- no grant lands on a slot that is not ready.

Some behaviours can only be shown by the bench's scenarios against its stamp-based reference model:
- that the winner is truly the oldest, especially after young entries have refilled low slots;
- that routing follows the class encoding;
- that a flush near the 255-to-0 inum wrap keeps exactly the older entries.

// File: rtl/iq_pkg.sv
package iq_pkg;

    localparam int UNITS     = 4;
    localparam int UNIT_W    = 2;
    localparam int CLS_W     = 2;

    typedef enum logic [CLS_W-1:0] {
        OP_ANY  = 2'd0,
        OP_MEM  = 2'd1,
        OP_SHF  = 2'd2,
        OP_ANY2 = 2'd3
    } op_cls_e;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_OPEN  = 2'd1,
        ST_FULL  = 2'd2
    } occ_state_e;

    // Fixed routing: memory ops pinned to the lower pair, shifts to the upper pair.
    function automatic logic [UNIT_W-1:0] route_unit(input logic [CLS_W-1:0] cls,
                                                     input logic [UNIT_W-1:0] route);
        logic [UNIT_W-1:0] u;
        unique case (cls)
            OP_MEM:          u = {1'b1, route[0]};
            OP_SHF:          u = {1'b0, route[0]};
            OP_ANY, OP_ANY2: u = route;
            default:         u = route;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/iq_alloc.sv
module iq_alloc #(
    parameter int DEPTH = 20,
    parameter int LANES = 4
) (
    input  logic [DEPTH-1:0]            free_mask,
    input  logic [LANES-1:0]            lane_req,
    output logic [LANES-1:0][DEPTH-1:0] lane_slot
);

    // Each requesting lane, in lane order, claims the lowest slot still unclaimed.
    always_comb begin
        logic [DEPTH-1:0] avail;
        logic             found;
        avail = free_mask;
        for (int k = 0; k < LANES; k++) begin
            lane_slot[k] = '0;
            found        = 1'b0;
            for (int s = 0; s < DEPTH; s++) begin
                if (lane_req[k] && avail[s] && !found) begin
                    lane_slot[k][s] = 1'b1;
                    found           = 1'b1;
                end
            end
            avail = avail & ~lane_slot[k];
        end
    end

endmodule

// File: rtl/iq_age.sv
module iq_age #(
    parameter int DEPTH = 20,
    parameter int LANES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LANES-1:0][DEPTH-1:0] lane_slot,
    output logic [DEPTH-1:0][DEPTH-1:0] older
);

    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [DEPTH-1:0]              is_new;
    logic [DEPTH-1:0][LANE_W-1:0]  rank;
    logic [DEPTH-1:0][DEPTH-1:0]   older_d;

    always_comb begin
        is_new = '0;
        rank   = '0;
        for (int k = 0; k < LANES; k++) begin
            for (int s = 0; s < DEPTH; s++) begin
                if (lane_slot[k][s]) begin
                    is_new[s] = 1'b1;
                    rank[s]   = LANE_W'(k);
                end
            end
        end
    end

    // older[i][j] : entry i entered before entry j
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            for (int j = 0; j < DEPTH; j++) begin
                if (i == j)                    older_d[i][j] = 1'b0;
                else if (is_new[i] && is_new[j]) older_d[i][j] = (rank[i] < rank[j]);
                else if (is_new[i])            older_d[i][j] = 1'b0;
                else if (is_new[j])            older_d[i][j] = 1'b1;
                else                           older_d[i][j] = older[i][j];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) older <= '0;
        else        older <= older_d;
    end

endmodule

// File: rtl/iq_half_arb.sv
module iq_half_arb #(
    parameter int DEPTH = 20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DEPTH-1:0][DEPTH-1:0] older,
    input  logic [1:0][DEPTH-1:0]     req,
    output logic [1:0][DEPTH-1:0]     gnt
);

    for (genvar u = 0; u < 2; u++) begin : g_sub
        logic [DEPTH-1:0] pick;

        // A requester wins when no other requester of this sub-cluster is older.
        always_comb begin
            for (int i = 0; i < DEPTH; i++) begin
                pick[i] = req[u][i];
                for (int j = 0; j < DEPTH; j++) begin
                    if (j != i && req[u][j] && older[j][i]) pick[i] = 1'b0;
                end
            end
        end

        assign gnt[u] = pick;

        AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(pick)) else $error("two winners on one sub-cluster"); // R5

        AST_SOMEONE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (|req[u]) |-> (|pick)) else $error("requests with no winner"); // R4
    end

endmodule

// File: rtl/iq_cluster_issue.sv
module iq_cluster_issue
    import iq_pkg::*;
#(
    parameter int DEPTH  = 20,
    parameter int LANES  = 4,
    parameter int INUM_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LANES-1:0]              ins_vld,
    input  logic [LANES-1:0][CLS_W-1:0]   ins_cls,
    input  logic [LANES-1:0][UNIT_W-1:0]  ins_route,
    input  logic [LANES-1:0][INUM_W-1:0]  ins_inum,
    input  logic [DEPTH-1:0]              slot_rdy,
    input  logic                          flush_vld,
    input  logic [INUM_W-1:0]             flush_inum,
    output logic                          full,
    output logic [UNITS-1:0]              gnt_vld,
    output logic [UNITS-1:0][INUM_W-1:0]  gnt_inum
);

    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int FULL_AT = DEPTH - LANES;
    localparam int HALVES  = UNITS / 2;

    occ_state_e st_q, st_d;

    logic [DEPTH-1:0]              v_q, v_d;
    logic [DEPTH-1:0][INUM_W-1:0]  inum_q;
    logic [DEPTH-1:0][UNIT_W-1:0]  unit_q;

    logic                          accept;
    logic [LANES-1:0]              lane_req;
    logic [LANES-1:0][DEPTH-1:0]   lane_slot;
    logic [DEPTH-1:0]              new_mask;
    logic [DEPTH-1:0][INUM_W-1:0]  new_inum;
    logic [DEPTH-1:0][UNIT_W-1:0]  new_unit;
    logic [DEPTH-1:0][DEPTH-1:0]   older;
    logic [UNITS-1:0][DEPTH-1:0]   req;
    logic [UNITS-1:0][DEPTH-1:0]   gnt;
    logic [DEPTH-1:0]              gnt_any;
    logic [DEPTH-1:0]              kill;
    logic [CNT_W-1:0]              occ_next;

    function automatic logic younger_than(input logic [INUM_W-1:0] a,
                                          input logic [INUM_W-1:0] b);
        logic [INUM_W-1:0] d;
        d = a - b;
        return (d != '0) && !d[INUM_W-1];
    endfunction

    // ---------------- occupancy state machine ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY: begin                               // fill / saturate
                if (occ_next > CNT_W'(FULL_AT))      st_d = ST_FULL;
                else if (occ_next != '0)             st_d = ST_OPEN;
            end
            ST_OPEN: begin                                // empty-out / saturate
                if (occ_next == '0)                  st_d = ST_EMPTY;
                else if (occ_next > CNT_W'(FULL_AT)) st_d = ST_FULL;
            end
            ST_FULL: begin                                // empty-out / drain
                if (occ_next == '0)                  st_d = ST_EMPTY;
                else if (occ_next <= CNT_W'(FULL_AT)) st_d = ST_OPEN;
            end
            default:                                 st_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        full     = (st_q == ST_FULL);
        accept   = !full && !flush_vld;
        lane_req = ins_vld & {LANES{accept}};
    end

    // ---------------- write path ----------------
    iq_alloc #(.DEPTH(DEPTH), .LANES(LANES)) u_alloc (
        .free_mask (~v_q),
        .lane_req  (lane_req),
        .lane_slot (lane_slot)
    );

    always_comb begin
        new_mask = '0;
        new_inum = '0;
        new_unit = '0;
        for (int k = 0; k < LANES; k++) begin
            for (int s = 0; s < DEPTH; s++) begin
                if (lane_slot[k][s]) begin
                    new_mask[s] = 1'b1;
                    new_inum[s] = ins_inum[k];
                    new_unit[s] = route_unit(ins_cls[k], ins_route[k]);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < DEPTH; s++) begin
            if (new_mask[s]) begin
                inum_q[s] <= new_inum[s];
                unit_q[s] <= new_unit[s];
            end
        end
    end

    iq_age #(.DEPTH(DEPTH), .LANES(LANES)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane_slot (lane_slot),
        .older     (older)
    );

    // ---------------- request and select ----------------
    always_comb begin
        for (int u = 0; u < UNITS; u++) begin
            for (int s = 0; s < DEPTH; s++) begin
                req[u][s] = v_q[s] && slot_rdy[s] && !flush_vld && (unit_q[s] == UNIT_W'(u));
            end
        end
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        logic [1:0][DEPTH-1:0] h_req;
        logic [1:0][DEPTH-1:0] h_gnt;
        assign h_req = {req[2*h+1], req[2*h]};

        iq_half_arb #(.DEPTH(DEPTH)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .older (older),
            .req   (h_req),
            .gnt   (h_gnt)
        );

        assign gnt[2*h]   = h_gnt[0];
        assign gnt[2*h+1] = h_gnt[1];
    end

    always_comb begin
        gnt_any = '0;
        for (int u = 0; u < UNITS; u++) begin
            gnt_vld[u]  = |gnt[u];
            gnt_inum[u] = '0;
            for (int s = 0; s < DEPTH; s++) begin
                if (gnt[u][s]) gnt_inum[u] = gnt_inum[u] | inum_q[s];
            end
            gnt_any = gnt_any | gnt[u];
        end
    end

    // ---------------- entry valid update ----------------
    always_comb begin
        for (int s = 0; s < DEPTH; s++) begin
            kill[s] = flush_vld && v_q[s] && younger_than(inum_q[s], flush_inum);
        end
        v_d = new_mask | (v_q & ~gnt_any & ~kill);
    end

    assign occ_next = CNT_W'($countones(v_d));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    // ---------------- assertions ----------------
    AST_FREED_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt_any) |=> ((v_q & $past(gnt_any)) == '0)) else $error("granted entry lingered"); // R5

    AST_NO_FILL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> ((v_q & ~$past(v_q)) == '0)) else $error("entry written while full"); // R8

    AST_NO_FILL_ON_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush_vld |=> ((v_q & ~$past(v_q)) == '0)) else $error("entry written during flush"); // R7

    AST_FULL_MATCHES_OCC: assert property (@(posedge clk) disable iff (!rst_n)
        full == ($countones(v_q) > FULL_AT)) else $error("full disagrees with occupancy"); // R8

    AST_GNT_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_any & ~(v_q & slot_rdy)) == '0) else $error("grant to idle slot"); // R3

endmodule

// File: tb/sim_iq_cluster_issue.sv
`timescale 1ns/1ps
module sim_iq_cluster_issue;

    localparam int DEPTH  = 20;
    localparam int LANES  = 4;
    localparam int INUM_W = 8;

    logic                        clk = 1'b0;
    logic                        rst_n = 1'b0;
    logic [LANES-1:0]            ins_vld;
    logic [LANES-1:0][1:0]       ins_cls;
    logic [LANES-1:0][1:0]       ins_route;
    logic [LANES-1:0][INUM_W-1:0] ins_inum;
    logic [DEPTH-1:0]            slot_rdy;
    logic                        flush_vld;
    logic [INUM_W-1:0]           flush_inum;
    logic                        full;
    logic [3:0]                  gnt_vld;
    logic [3:0][INUM_W-1:0]      gnt_inum;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model: per-slot valid, insertion stamp, target unit, tag
    bit m_v[DEPTH];
    int m_stamp[DEPTH];
    int m_unit[DEPTH];
    int m_inum[DEPTH];
    int stamp_ctr = 0;
    int inum_ctr  = 0;

    always #2.5 clk = ~clk;

    iq_cluster_issue #(.DEPTH(DEPTH), .LANES(LANES), .INUM_W(INUM_W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ins_vld    (ins_vld),
        .ins_cls    (ins_cls),
        .ins_route  (ins_route),
        .ins_inum   (ins_inum),
        .slot_rdy   (slot_rdy),
        .flush_vld  (flush_vld),
        .flush_inum (flush_inum),
        .full       (full),
        .gnt_vld    (gnt_vld),
        .gnt_inum   (gnt_inum)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
        end
    endtask

    function automatic int unit_of(input int cls, input int route);
        if (cls == 1) return 2 + (route % 2);
        if (cls == 2) return route % 2;
        return route;
    endfunction

    function automatic bit younger(input int a, input int f);
        int d;
        d = (a - f + 256) % 256;
        return (d >= 1) && (d <= 127);
    endfunction

    task automatic clear_inputs();
        ins_vld    = '0;
        ins_cls    = '0;
        ins_route  = '0;
        ins_inum   = '0;
        flush_vld  = 1'b0;
        flush_inum = '0;
    endtask

    task automatic put(input int k, input int cls, input int route);
        ins_vld[k]   = 1'b1;
        ins_cls[k]   = 2'(cls);
        ins_route[k] = 2'(route);
        ins_inum[k]  = 8'(inum_ctr);
        inum_ctr     = (inum_ctr + 1) % 256;
    endtask

    // Called just after a falling edge with inputs set; compares, then advances one clock.
    task automatic step(input string tag);
        int cnt;
        bit efull;
        int best;
        bit found;
        bit nv[DEPTH];
        bit taken[DEPTH];
        #1;
        cnt = 0;
        for (int s = 0; s < DEPTH; s++) cnt += int'(m_v[s]);
        efull = (cnt > DEPTH - LANES);
        chk(tag, "full (R8)", int'(full), int'(efull));
        for (int s = 0; s < DEPTH; s++) nv[s] = m_v[s];
        for (int u = 0; u < 4; u++) begin
            best = -1;
            if (!flush_vld) begin
                for (int s = 0; s < DEPTH; s++) begin
                    if (m_v[s] && slot_rdy[s] && m_unit[s] == u &&
                        (best < 0 || m_stamp[s] < m_stamp[best])) best = s;
                end
            end
            chk(tag, $sformatf("gnt_vld[%0d]", u), int'(gnt_vld[u]), int'(best >= 0));
            if (best >= 0) begin
                chk(tag, $sformatf("gnt_inum[%0d] (R9)", u), int'(gnt_inum[u]), m_inum[best]);
                nv[best] = 1'b0;
            end
        end
        if (flush_vld) begin
            for (int s = 0; s < DEPTH; s++)
                if (m_v[s] && younger(m_inum[s], int'(flush_inum))) nv[s] = 1'b0;
        end else if (!efull) begin
            for (int s = 0; s < DEPTH; s++) taken[s] = m_v[s];
            for (int k = 0; k < LANES; k++) begin
                if (ins_vld[k]) begin
                    found = 1'b0;
                    for (int s = 0; s < DEPTH; s++) begin
                        if (!taken[s] && !found) begin
                            found      = 1'b1;
                            taken[s]   = 1'b1;
                            nv[s]      = 1'b1;
                            m_stamp[s] = stamp_ctr;
                            stamp_ctr++;
                            m_unit[s]  = unit_of(int'(ins_cls[k]), int'(ins_route[k]));
                            m_inum[s]  = int'(ins_inum[k]);
                        end
                    end
                end
            end
        end
        @(posedge clk);
        for (int s = 0; s < DEPTH; s++) m_v[s] = nv[s];
        @(negedge clk);
    endtask

    task automatic drain(input string tag);
        clear_inputs();
        slot_rdy = '1;
        repeat (8) step(tag);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < DEPTH; s++) begin
            m_v[s] = 1'b0; m_stamp[s] = 0; m_unit[s] = 0; m_inum[s] = 0;
        end
        clear_inputs();
        slot_rdy = '1;
        repeat (3) @(negedge clk);
        // R1: reset state
        #1;
        chk("R1", "full in reset", int'(full), 0);
        chk("R1", "gnt_vld in reset", int'(gnt_vld), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step("R1");
        step("R1");

        // R2: class routing (mem->L0, shift->U1, any->U0, mem->L1)
        put(0, 1, 0);
        put(1, 2, 3);
        put(2, 0, 0);
        put(3, 1, 1);
        step("R2");
        clear_inputs();
        #1;
        chk("R2", "all four units granted", int'(gnt_vld), 15);
        step("R2");
        drain("R2");

        // R3: readiness gating
        slot_rdy = '0;
        for (int k = 0; k < 4; k++) put(k, 0, k);
        step("R3");
        clear_inputs();
        step("R3");
        step("R3");
        slot_rdy = 20'h00002;
        step("R3");
        drain("R3");

        // R4: oldest first, independent of slot number
        slot_rdy = '0;
        for (int c = 0; c < 3; c++) begin
            clear_inputs();
            for (int k = 0; k < 4; k++) put(k, 0, 0);
            step("R4");
        end
        clear_inputs();
        slot_rdy = 20'h0003F;
        repeat (6) step("R4");
        slot_rdy = '0;
        for (int k = 0; k < 4; k++) put(k, 0, 0);
        step("R4");
        clear_inputs();
        slot_rdy = '1;
        repeat (10) step("R4");
        drain("R4");

        // R6: freed slot reused next cycle
        slot_rdy = '1;
        for (int c = 0; c < 6; c++) begin
            clear_inputs();
            put(0, 2, c % 2);
            step("R6");
        end
        drain("R6");

        // R7: flush across the inum wrap
        inum_ctr = 250;
        slot_rdy = '0;
        for (int c = 0; c < 3; c++) begin
            clear_inputs();
            for (int k = 0; k < 4; k++) put(k, 0, k);
            step("R7");
        end
        clear_inputs();
        put(0, 0, 0);
        flush_vld  = 1'b1;
        flush_inum = 8'd253;
        slot_rdy   = '1;
        step("R7");
        clear_inputs();
        repeat (3) step("R7");
        drain("R7");

        // R8: fill to full, writes stalled
        slot_rdy = '0;
        for (int c = 0; c < 7; c++) begin
            clear_inputs();
            for (int k = 0; k < 4; k++) put(k, 0, k);
            step("R8");
        end
        clear_inputs();
        slot_rdy = 20'h00001;
        for (int k = 0; k < 4; k++) put(k, 0, 1);
        step("R8");
        slot_rdy = 20'h0000F;
        repeat (4) step("R8");
        drain("R8");

        // R5 / R9: random traffic
        for (int c = 0; c < 3000; c++) begin
            clear_inputs();
            for (int k = 0; k < 4; k++)
                if ($urandom_range(0, 2) == 0) put(k, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
            slot_rdy = 20'($urandom);
            if ($urandom_range(0, 49) == 0) begin
                flush_vld  = 1'b1;
                flush_inum = 8'(inum_ctr - 1 - int'($urandom_range(0, 12)));
            end
            step("R5");
        end
        drain("R9");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule